// File: doc/BRIEF.md
# Tree Switch Route Decision

This block makes the forwarding choice inside one switch of a k-ary tree network. Every leaf has an address of DEPTH digits, each RADIX_BITS wide (radix 2 or radix 4). The digits spell out the path from the root down to that leaf. A route climbs to the lowest common ancestor of source and destination, then descends. It never turns upward again once it has started down. Each switch has one parent port and 2^RADIX_BITS child ports.

When a header is injected, the block takes the exclusive-OR of source and destination. The highest digit position i that differs sets the climb length to i+1 levels. The count of levels still to climb travels in the header and drops by one on every upward hop. When it reaches zero, the switch picks the child port named by the destination digit at the switch's own level, with level 0 being the switches next to the leaves.

A header whose source equals its destination is delivered at once: a local flag is raised and no port is selected. Headers enter on a valid/ready handshake. The decision is held on the output until the consumer takes it.

The controller has two states:
- **ST_IDLE**: ready is high. The transition **accept** (in_valid while ready) registers the decision and moves to ST_HOLD.
- **ST_HOLD**: the output is valid. The transition **release** (out_ready) returns to ST_IDLE. While out_ready is low, the transition **stall** keeps the state and the output unchanged.

Top module: `tree_route_sw`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, port_sel is 0, climb_out is 0 and local_flag is 0.
- R2: A header offered while in_ready is 1 is taken on that clock edge. out_valid is 1 from the next cycle, and in_ready stays 0 while out_valid is 1.
- R3: While out_valid is 1 and out_ready is 0, port_sel, climb_out and local_flag hold their values, and new headers are not taken. A cycle with out_valid and out_ready both 1 is followed by out_valid 0 and in_ready 1.
- R4: For an injected header (in_inject 1), the effective count is i+1, where i is the index of the highest digit (digit j = address bits [j*RADIX_BITS +: RADIX_BITS]) in which in_src and in_dst differ. If that count exceeds 1, the header goes to the parent and climb_out is i.
- R5: For a header that is not injected, the effective count is in_climb. If it exceeds 1, the header goes to the parent and climb_out is in_climb-1.
- R6: If the effective count is 0 or 1, the header goes to child port c, where c is the digit of in_dst at position sw_level, and climb_out is 0.
- R7: An injected header with in_src equal to in_dst raises local_flag, with port_sel 0 and climb_out 0. A header that is not injected never raises local_flag, even if its addresses match.
- R8: port_sel encodes the parent as bit 0 and child c as bit c+1. At most one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Block can take a header |
| in_inject | input | 1 | Header is fresh from its source leaf; the climb count is computed here |
| in_src | input | DEPTH*RADIX_BITS | Source leaf address |
| in_dst | input | DEPTH*RADIX_BITS | Destination leaf address |
| in_climb | input | $clog2(DEPTH+1) | Levels still to climb, as carried in the header |
| sw_level | input | $clog2(DEPTH) | Level of this switch, 0 next to the leaves |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Consumer takes the decision |
| port_sel | output | 2^RADIX_BITS+1 | One-hot port choice: bit 0 parent, bit c+1 child c |
| climb_out | output | $clog2(DEPTH+1) | Updated climb count for the header |
| local_flag | output | 1 | Source equals destination; delivered without a hop |

## Verification
The properties assume that sw_level is below DEPTH and that in_climb never exceeds DEPTH. They also assume the consumer may hold out_ready low for any number of cycles. The bench applies only legal levels and climb values taken from real routes. These include a full trip of one header that climbs from level 0, turns at level 2 and descends again. It also keeps out_ready low for several cycles while offering further headers, to exercise the stall path.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rt_state_e;

    localparam int PORT_PARENT = 0;
endpackage

// File: rtl/tree_msd_find.sv
module tree_msd_find #(
    parameter int RADIX_BITS = 2,
    parameter int DEPTH      = 4,
    localparam int ADDR_W    = DEPTH * RADIX_BITS,
    localparam int CLIMB_W   = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0]  src,
    input  logic [ADDR_W-1:0]  dst,
    output logic               any_diff,
    output logic [CLIMB_W-1:0] msd_idx
);
    logic [ADDR_W-1:0] rel;
    logic [DEPTH-1:0]  dig_nz;

    assign rel = src ^ dst;

    for (genvar j = 0; j < DEPTH; j++) begin : g_dig
        assign dig_nz[j] = |rel[j*RADIX_BITS +: RADIX_BITS];
    end

    assign any_diff = |dig_nz;

    always_comb begin
        msd_idx = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (dig_nz[j]) msd_idx = CLIMB_W'(j);
        end
    end
endmodule

// File: rtl/tree_port_pick.sv
module tree_port_pick
    import tree_route_pkg::*;
#(
    parameter int RADIX_BITS = 2,
    parameter int DEPTH      = 4,
    localparam int ADDR_W    = DEPTH * RADIX_BITS,
    localparam int CLIMB_W   = $clog2(DEPTH + 1),
    localparam int LVL_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PORT_W    = (1 << RADIX_BITS) + 1
) (
    input  logic               inject,
    input  logic [CLIMB_W-1:0] climb_in,
    input  logic               any_diff,
    input  logic [CLIMB_W-1:0] msd_idx,
    input  logic [LVL_W-1:0]   level,
    input  logic [ADDR_W-1:0]  dst,
    output logic [PORT_W-1:0]  sel,
    output logic [CLIMB_W-1:0] climb_nx,
    output logic               local_hit
);
    logic [RADIX_BITS-1:0] dst_dig [DEPTH];
    logic [RADIX_BITS-1:0] here_dig;
    logic [CLIMB_W-1:0]    eff;

    for (genvar j = 0; j < DEPTH; j++) begin : g_split
        assign dst_dig[j] = dst[j*RADIX_BITS +: RADIX_BITS];
    end

    assign here_dig = dst_dig[level];
    assign eff      = inject ? (msd_idx + CLIMB_W'(1)) : climb_in;

    always_comb begin
        sel       = '0;
        climb_nx  = '0;
        local_hit = 1'b0;
        if (inject && !any_diff) begin
            local_hit = 1'b1;
        end else if (eff > CLIMB_W'(1)) begin
            sel[PORT_PARENT] = 1'b1;
            climb_nx         = eff - CLIMB_W'(1);
        end else begin
            sel = PORT_W'(2) << here_dig;
        end
    end
endmodule

// File: rtl/tree_route_sw.sv
module tree_route_sw
    import tree_route_pkg::*;
#(
    parameter int RADIX_BITS = 2,
    parameter int DEPTH      = 4,
    localparam int ADDR_W    = DEPTH * RADIX_BITS,
    localparam int CLIMB_W   = $clog2(DEPTH + 1),
    localparam int LVL_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PORT_W    = (1 << RADIX_BITS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_inject,
    input  logic [ADDR_W-1:0]  in_src,
    input  logic [ADDR_W-1:0]  in_dst,
    input  logic [CLIMB_W-1:0] in_climb,
    input  logic [LVL_W-1:0]   sw_level,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PORT_W-1:0]  port_sel,
    output logic [CLIMB_W-1:0] climb_out,
    output logic               local_flag
);
    rt_state_e          state_q, state_d;
    logic               any_diff;
    logic [CLIMB_W-1:0] msd_idx;
    logic [PORT_W-1:0]  sel_d, sel_q;
    logic [CLIMB_W-1:0] climb_d, climb_q;
    logic               local_d, local_q;
    logic               take;

    tree_msd_find #(.RADIX_BITS(RADIX_BITS), .DEPTH(DEPTH)) u_msd (
        .src      (in_src),
        .dst      (in_dst),
        .any_diff (any_diff),
        .msd_idx  (msd_idx)
    );

    tree_port_pick #(.RADIX_BITS(RADIX_BITS), .DEPTH(DEPTH)) u_pick (
        .inject    (in_inject),
        .climb_in  (in_climb),
        .any_diff  (any_diff),
        .msd_idx   (msd_idx),
        .level     (sw_level),
        .dst       (in_dst),
        .sel       (sel_d),
        .climb_nx  (climb_d),
        .local_hit (local_d)
    );

    assign take = in_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            climb_q <= '0;
            local_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                sel_q   <= sel_d;
                climb_q <= climb_d;
                local_q <= local_d;
            end
        end
    end

    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_HOLD: out_valid = 1'b1;
        endcase
        port_sel   = sel_q;
        climb_out  = climb_q;
        local_flag = local_q;
    end
endmodule

// File: rtl/tree_route_sw_chk.sv
module tree_route_sw_chk #(
    parameter int RADIX_BITS = 2,
    parameter int DEPTH      = 4,
    localparam int CLIMB_W   = $clog2(DEPTH + 1),
    localparam int PORT_W    = (1 << RADIX_BITS) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [PORT_W-1:0]  port_sel,
    input logic [CLIMB_W-1:0] climb_out,
    input logic               local_flag
);
    AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(port_sel)
            && $stable(climb_out) && $stable(local_flag))); // R3
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready)); // R3
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel)); // R8
    AST_UP_HAS_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && port_sel[0]) |-> (climb_out != '0)); // R5
    AST_DOWN_NO_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (|port_sel[PORT_W-1:1])) |-> (climb_out == '0)); // R6
    AST_LOCAL_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && local_flag) |-> (port_sel == '0 && climb_out == '0)); // R7
endmodule

bind tree_route_sw tree_route_sw_chk #(.RADIX_BITS(RADIX_BITS), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .port_sel   (port_sel),
    .climb_out  (climb_out),
    .local_flag (local_flag)
);

// File: tb/tree_route_sw_bench.sv
module tree_route_sw_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RB  = 2;
    localparam int DP  = 4;
    localparam int AW  = DP * RB;
    localparam int CW  = $clog2(DP + 1);
    localparam int LW  = $clog2(DP);
    localparam int PW  = (1 << RB) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_inject = 1'b0;
    logic [AW-1:0] in_src = '0;
    logic [AW-1:0] in_dst = '0;
    logic [CW-1:0] in_climb = '0;
    logic [LW-1:0] sw_level = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [PW-1:0] port_sel;
    logic [CW-1:0] climb_out;
    logic          local_flag;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tree_route_sw #(.RADIX_BITS(RB), .DEPTH(DP)) u_tree_route_sw (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_inject(in_inject), .in_src(in_src), .in_dst(in_dst),
        .in_climb(in_climb), .sw_level(sw_level), .out_valid(out_valid),
        .out_ready(out_ready), .port_sel(port_sel), .climb_out(climb_out),
        .local_flag(local_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic route(input logic inj, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input logic [CW-1:0] c, input logic [LW-1:0] lvl,
                         input int exp_sel, input int exp_climb, input int exp_loc,
                         input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_inject = inj; in_src = s; in_dst = d;
        in_climb = c; sw_level = lvl; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 out_valid"}, int'(out_valid), 1);
        chk({tag, " R2 in_ready"}, int'(in_ready), 0);
        chk({tag, " R8 port_sel"}, int'(port_sel), exp_sel);
        chk({tag, " climb_out"}, int'(climb_out), exp_climb);
        chk({tag, " R7 local_flag"}, int'(local_flag), exp_loc);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({tag, " R3 released"}, int'(out_valid), 0);
        chk({tag, " R3 ready back"}, int'(in_ready), 1);
    endtask

    task automatic stall_test();
        @(negedge clk);
        in_valid = 1'b1; in_inject = 1'b1; in_src = 8'h00; in_dst = 8'h20;
        sw_level = 2'd0; out_ready = 1'b0;
        @(negedge clk);
        in_dst = 8'h01;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 stall sel", int'(port_sel), 1);
            chk("R3 stall climb", int'(climb_out), 2);
            chk("R3 stall valid", int'(out_valid), 1);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R3 stall release", int'(in_ready), 1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*2 + 1);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 port_sel", int'(port_sel), 0);
        chk("R1 climb_out", int'(climb_out), 0);
        chk("R1 local_flag", int'(local_flag), 0);
        rst_n = 1'b1;

        // R7 local delivery on injection
        route(1'b1, 8'h00, 8'h00, 3'd0, 2'd0, 0, 0, 1, "R7 zero");
        route(1'b1, 8'h5A, 8'h5A, 3'd0, 2'd0, 0, 0, 1, "R7 same");
        // R7 non-injected equal addresses go to child 2 (bit 3)
        route(1'b0, 8'h5A, 8'h5A, 3'd0, 2'd0, 8, 0, 0, "R7 noinj");
        // R4/R6 differ in digit 0 only: turn at level 0, child 2
        route(1'b1, 8'h1B, 8'h1A, 3'd0, 2'd0, 8, 0, 0, "R6 i0");
        // R4 full trip: differ in digit 2 (upper bit of that digit)
        route(1'b1, 8'h00, 8'h20, 3'd0, 2'd0, 1, 2, 0, "R4 up0");
        route(1'b0, 8'h00, 8'h20, 3'd2, 2'd1, 1, 1, 0, "R5 up1");
        route(1'b0, 8'h00, 8'h20, 3'd1, 2'd2, 8, 0, 0, "R6 turn2");
        route(1'b0, 8'h00, 8'h20, 3'd0, 2'd1, 2, 0, 0, "R6 down1");
        route(1'b0, 8'h00, 8'h20, 3'd0, 2'd0, 2, 0, 0, "R6 down0");
        // R4 top digit differs: climb count 3
        route(1'b1, 8'h00, 8'hC0, 3'd0, 2'd0, 1, 3, 0, "R4 top");
        route(1'b0, 8'h00, 8'hC0, 3'd0, 2'd3, 16, 0, 0, "R6 top");
        // R4 injection ignores in_climb
        route(1'b1, 8'h40, 8'h80, 3'd0, 2'd0, 1, 3, 0, "R4 ignclimb");

        stall_test();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule